// File: doc/BRIEF.md
# Converter Sample Buffer with Interrupt Registers

This block sits between an analog conversion controller and a host processor. The controller hands over each finished conversion result on a push port. The block keeps the results in a small first-in, first-out store and lets the host drain them through a memory-mapped register window. While the store holds data, an interrupt source is active. That source passes through a status bit, a per-source enable and a global enable before it reaches the registered interrupt output.

The host reaches the block over a simple single-beat bus. A request is one cycle of `bus_req` with an address, a write flag, write data and byte enables. The block returns `bus_ack` in the following cycle, together with read data and, where it applies, `bus_err`. A control register drives the conversion-enable bit and the filter-settle multiplier to the conversion controller. Word bit 31 is the most significant bit. The window is 0x200 bytes wide.

Top module: `sample_buffer_regs`

## Requirements
- R1: After reset, every register reads 0, and `irq`, `conv_en` and `settle_mult` are 0.
- R2: Every cycle with `bus_req` high is answered by `bus_ack` high for exactly the next cycle. With no request, `bus_ack` stays low.
- R3: Offset 0x01C holds the global enable at word bit 31. Offset 0x028 holds the interrupt enable at bit 0. Offset 0x100 holds conversion-enable at bit 31 and the settle multiplier in bits FSTM_W-1:0. All other bits read 0. A byte lane is written only when its enable is set: `bus_be[3]` covers bits 31:24 and `bus_be[0]` covers bits 7:0.
- R4: Each read of 0x104 pops the oldest sample, right-justified in bits SAMPLE_W-1:0. Offset 0x108 returns the sample count from 0 to DEPTH in its low bits.
- R5: A read of 0x104 while the store is empty returns `bus_err` with the ack, and it leaves the count unchanged.
- R6: A sample pushed while the store holds DEPTH samples is dropped. The count stays DEPTH, and the stored order is unchanged.
- R7: A push in the same cycle as a pop on a full store is accepted. The count stays DEPTH, and the new sample joins at the tail.
- R8: The status bit (offset 0x020, bit 0) is set on every cycle in which the store is non-empty. A toggle written while data remains is overridden.
- R9: Writing 1 to status bit 0 toggles it, so it can both clear and set. Writing 0 leaves it unchanged.
- R10: `irq` is the AND of the global enable, the interrupt enable and the status bit, registered one cycle behind those bits.
- R11: Writes to 0x104 and 0x108 change nothing. Reads of unmapped offsets return 0 without error.
- R12: `conv_en` and `settle_mult` follow the control register fields.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_req | input | 1 | Access request, one access per cycle |
| bus_we | input | 1 | 1 for write, 0 for read |
| bus_addr | input | ADDR_W | Byte address within the window |
| bus_wdata | input | 32 | Write data |
| bus_be | input | 4 | Byte enables, bit 3 for the top byte |
| bus_rdata | output | 32 | Read data, valid with the ack |
| bus_ack | output | 1 | Access acknowledge |
| bus_err | output | 1 | Access error (read of an empty store) |
| smp_valid | input | 1 | Sample push strobe |
| smp_data | input | SAMPLE_W | Sample value |
| conv_en | output | 1 | Conversion enable to the controller |
| settle_mult | output | FSTM_W | Filter-settle multiplier to the controller |
| irq | output | 1 | Registered interrupt request |

## Verification
A corrupted pointer or count shows up at the ports at the next read of 0x104 or 0x108. It appears either as a sample out of order or duplicated, or as a wrong occupancy value, one cycle after the request. A wrong status or enable bit shows on `irq` two cycles after the stimulus that should have changed it, and in the read-back at 0x020 one cycle after the access. A mis-handled full condition appears only when the bench drains the store completely. That is why the full-store cases end with a read of every entry.

// File: rtl/sbr_pkg.sv
package sbr_pkg;
  localparam int WORD_W = 32;

  localparam logic [8:0] OFS_GIE  = 9'h01C;
  localparam logic [8:0] OFS_ISR  = 9'h020;
  localparam logic [8:0] OFS_IER  = 9'h028;
  localparam logic [8:0] OFS_CTRL = 9'h100;
  localparam logic [8:0] OFS_FIFO = 9'h104;
  localparam logic [8:0] OFS_OCC  = 9'h108;

  typedef logic [WORD_W-1:0] word_t;

  typedef enum logic [2:0] {
    SEL_NONE,
    SEL_GIE,
    SEL_ISR,
    SEL_IER,
    SEL_CTRL,
    SEL_FIFO,
    SEL_OCC
  } reg_sel_e;

  function automatic reg_sel_e decode_sel(input logic [8:2] wa);
    reg_sel_e s;
    s = SEL_NONE;
    if (wa == OFS_GIE[8:2])  s = SEL_GIE;
    if (wa == OFS_ISR[8:2])  s = SEL_ISR;
    if (wa == OFS_IER[8:2])  s = SEL_IER;
    if (wa == OFS_CTRL[8:2]) s = SEL_CTRL;
    if (wa == OFS_FIFO[8:2]) s = SEL_FIFO;
    if (wa == OFS_OCC[8:2])  s = SEL_OCC;
    return s;
  endfunction
endpackage

// File: rtl/sbr_sample_fifo.sv
module sbr_sample_fifo #(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 16,
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              push,
  input  logic [DATA_W-1:0] push_data,
  input  logic              pop,
  output logic [DATA_W-1:0] q,
  output logic [CNT_W-1:0]  count,
  output logic              empty,
  output logic              full
);
  logic [DATA_W-1:0] mem [DEPTH];
  logic [PTR_W-1:0]  wr_ptr, rd_ptr;
  logic              do_push, do_pop;

  assign empty   = (count == '0);
  assign full    = (count == CNT_W'(DEPTH));
  assign do_pop  = pop & ~empty;
  assign do_push = push & (~full | do_pop);

  function automatic logic [PTR_W-1:0] next_ptr(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  // storage without reset so that a block RAM can hold it
  always_ff @(posedge clk) begin
    if (do_push) mem[wr_ptr] <= push_data;
  end

  always_ff @(posedge clk) begin
    if (do_pop) q <= mem[rd_ptr];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (do_push) wr_ptr <= next_ptr(wr_ptr);
      if (do_pop)  rd_ptr <= next_ptr(rd_ptr);
      case ({do_push, do_pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  // R4
  cnt_range_chk: assert property (@(posedge clk) disable iff (rst)
    count <= CNT_W'(DEPTH)) else $error("count above depth");

  // R6
  full_drop_chk: assert property (@(posedge clk) disable iff (rst)
    (full && push && !pop) |=> full) else $error("full push changed count");

  // R7
  full_swap_chk: assert property (@(posedge clk) disable iff (rst)
    (full && push && pop) |=> full) else $error("push with pop on full lost a slot");
endmodule

// File: rtl/sbr_irq_unit.sv
module sbr_irq_unit (
  input  logic clk,
  input  logic rst,
  input  logic gie_wr,
  input  logic gie_val,
  input  logic ier_wr,
  input  logic ier_val,
  input  logic stat_toggle,
  input  logic level_src,
  output logic gie_q,
  output logic ier_q,
  output logic stat_q,
  output logic irq
);
  always_ff @(posedge clk) begin
    if (rst) begin
      gie_q  <= 1'b0;
      ier_q  <= 1'b0;
      stat_q <= 1'b0;
      irq    <= 1'b0;
    end else begin
      if (gie_wr) gie_q <= gie_val;
      if (ier_wr) ier_q <= ier_val;
      stat_q <= (stat_q ^ stat_toggle) | level_src;
      irq    <= gie_q & ier_q & stat_q;
    end
  end

  // R8
  stat_set_chk: assert property (@(posedge clk) disable iff (rst)
    level_src |=> stat_q) else $error("status not set by pending data");

  // R9
  stat_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!level_src && !stat_toggle) |=> $stable(stat_q)) else $error("status changed without cause");

  // R10
  irq_src_chk: assert property (@(posedge clk) disable iff (rst)
    irq |-> ($past(stat_q) && $past(gie_q) && $past(ier_q))) else $error("irq without enabled source");
endmodule

// File: rtl/sample_buffer_regs.sv
module sample_buffer_regs
  import sbr_pkg::*;
#(
  parameter int SAMPLE_W = 8,
  parameter int DEPTH    = 16,
  parameter int FSTM_W   = 4,
  parameter int ADDR_W   = 9,
  localparam int CNT_W   = $clog2(DEPTH + 1)
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                bus_req,
  input  logic                bus_we,
  input  logic [ADDR_W-1:0]   bus_addr,
  input  logic [31:0]         bus_wdata,
  input  logic [3:0]          bus_be,
  output logic [31:0]         bus_rdata,
  output logic                bus_ack,
  output logic                bus_err,
  input  logic                smp_valid,
  input  logic [SAMPLE_W-1:0] smp_data,
  output logic                conv_en,
  output logic [FSTM_W-1:0]   settle_mult,
  output logic                irq
);
  reg_sel_e          sel;
  logic              acc_rd, acc_wr;
  logic              pop_go, err_d;
  logic [SAMPLE_W-1:0] fifo_q;
  logic [CNT_W-1:0]  fifo_cnt;
  logic              fifo_empty, fifo_full;
  logic              gie_q, ier_q, stat_q;
  logic              fifo_rd_q;
  word_t             rd_mux, rdata_q;
  logic              unused_bits;

  assign sel    = decode_sel(bus_addr[8:2]);
  assign acc_rd = bus_req & ~bus_we;
  assign acc_wr = bus_req & bus_we;
  assign pop_go = acc_rd & (sel == SEL_FIFO) & ~fifo_empty;
  assign err_d  = acc_rd & (sel == SEL_FIFO) & fifo_empty;
  assign unused_bits = ^{bus_wdata, bus_be, bus_addr};

  sbr_sample_fifo #(.DATA_W(SAMPLE_W), .DEPTH(DEPTH)) u_fifo (
    .clk       (clk),
    .rst       (rst),
    .push      (smp_valid),
    .push_data (smp_data),
    .pop       (pop_go),
    .q         (fifo_q),
    .count     (fifo_cnt),
    .empty     (fifo_empty),
    .full      (fifo_full)
  );

  sbr_irq_unit u_irq (
    .clk         (clk),
    .rst         (rst),
    .gie_wr      (acc_wr & (sel == SEL_GIE) & bus_be[3]),
    .gie_val     (bus_wdata[31]),
    .ier_wr      (acc_wr & (sel == SEL_IER) & bus_be[0]),
    .ier_val     (bus_wdata[0]),
    .stat_toggle (acc_wr & (sel == SEL_ISR) & bus_be[0] & bus_wdata[0]),
    .level_src   (~fifo_empty),
    .gie_q       (gie_q),
    .ier_q       (ier_q),
    .stat_q      (stat_q),
    .irq         (irq)
  );

  // control register: enable in the top lane, multiplier in the bottom lane
  always_ff @(posedge clk) begin
    if (rst) begin
      conv_en     <= 1'b0;
      settle_mult <= '0;
    end else if (acc_wr && sel == SEL_CTRL) begin
      if (bus_be[3]) conv_en     <= bus_wdata[31];
      if (bus_be[0]) settle_mult <= bus_wdata[FSTM_W-1:0];
    end
  end

  always_comb begin
    rd_mux = '0;
    case (sel)
      SEL_GIE:  rd_mux[31] = gie_q;
      SEL_ISR:  rd_mux[0]  = stat_q;
      SEL_IER:  rd_mux[0]  = ier_q;
      SEL_CTRL: begin
        rd_mux[31]         = conv_en;
        rd_mux[FSTM_W-1:0] = settle_mult;
      end
      SEL_OCC:  rd_mux[CNT_W-1:0] = fifo_cnt;
      default:  rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_ack   <= 1'b0;
      bus_err   <= 1'b0;
      fifo_rd_q <= 1'b0;
      rdata_q   <= '0;
    end else begin
      bus_ack   <= bus_req;
      bus_err   <= err_d;
      fifo_rd_q <= pop_go;
      rdata_q   <= acc_rd ? rd_mux : '0;
    end
  end

  assign bus_rdata = fifo_rd_q ? {{(32-SAMPLE_W){1'b0}}, fifo_q} : rdata_q;

  // R2
  ack_follow_chk: assert property (@(posedge clk) disable iff (rst)
    bus_req |=> bus_ack) else $error("request not acknowledged");

  // R2
  ack_idle_chk: assert property (@(posedge clk) disable iff (rst)
    !bus_req |=> !bus_ack) else $error("ack without request");

  // R5
  err_empty_chk: assert property (@(posedge clk) disable iff (rst)
    (acc_rd && sel == SEL_FIFO && fifo_empty) |=> (bus_err && bus_ack)) else $error("empty read not flagged");

  // R5
  err_ack_chk: assert property (@(posedge clk) disable iff (rst)
    bus_err |-> bus_ack) else $error("error without ack");
endmodule

// File: tb/sample_buffer_regs_bench.sv
module sample_buffer_regs_bench;
  localparam int SW = 8;
  localparam int FW = 4;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_req = 1'b0, bus_we = 1'b0;
  logic [8:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [3:0]  bus_be = '0;
  logic [31:0] bus_rdata;
  logic        bus_ack, bus_err;
  logic        smp_valid = 1'b0;
  logic [SW-1:0] smp_data = '0;
  logic        conv_en;
  logic [FW-1:0] settle_mult;
  logic        irq;

  int checks = 0;
  int failures = 0;

  always #5 clk = ~clk;

  sample_buffer_regs #(.SAMPLE_W(SW), .DEPTH(16), .FSTM_W(FW), .ADDR_W(9)) u_sample_buffer_regs (
    .clk(clk), .rst(rst), .bus_req(bus_req), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_be(bus_be), .bus_rdata(bus_rdata), .bus_ack(bus_ack),
    .bus_err(bus_err), .smp_valid(smp_valid), .smp_data(smp_data), .conv_en(conv_en),
    .settle_mult(settle_mult), .irq(irq)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [8:0] a, input logic [31:0] d, input logic [3:0] be);
    @(negedge clk);
    bus_req = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d; bus_be = be;
    @(posedge clk);
    @(negedge clk);
    bus_req = 1'b0; bus_we = 1'b0;
  endtask

  task automatic bus_rd(input logic [8:0] a, output logic [31:0] d, output logic e);
    @(negedge clk);
    bus_req = 1'b1; bus_we = 1'b0; bus_addr = a;
    @(posedge clk);
    @(negedge clk);
    d = bus_rdata; e = bus_err;
    bus_req = 1'b0;
  endtask

  task automatic push(input logic [SW-1:0] v);
    @(negedge clk);
    smp_valid = 1'b1; smp_data = v;
    @(posedge clk);
    @(negedge clk);
    smp_valid = 1'b0;
  endtask

  task automatic t_reset();
    logic [31:0] d; logic e;
    check("R1 irq", 32'(irq), 0);
    check("R1 conv_en", 32'(conv_en), 0);
    check("R1 settle_mult", 32'(settle_mult), 0);
    bus_rd(9'h01C, d, e); check("R1 gie", d, 0);
    bus_rd(9'h020, d, e); check("R1 isr", d, 0);
    bus_rd(9'h028, d, e); check("R1 ier", d, 0);
    bus_rd(9'h100, d, e); check("R1 ctrl", d, 0);
    bus_rd(9'h108, d, e); check("R1 occ", d, 0);
  endtask

  task automatic t_ack();
    @(negedge clk);
    check("R2 idle ack", 32'(bus_ack), 0);
    bus_req = 1'b1; bus_we = 1'b0; bus_addr = 9'h108;
    @(posedge clk); @(negedge clk);
    bus_req = 1'b0;
    check("R2 ack one cycle later", 32'(bus_ack), 1);
    @(posedge clk); @(negedge clk);
    check("R2 ack drops", 32'(bus_ack), 0);
  endtask

  task automatic t_regs();
    logic [31:0] d; logic e;
    bus_wr(9'h01C, 32'h8000_0000, 4'hF);
    bus_rd(9'h01C, d, e); check("R3 gie bit31", d, 32'h8000_0000);
    bus_wr(9'h028, 32'hFFFF_FFFF, 4'hF);
    bus_rd(9'h028, d, e); check("R3 ier bit0", d, 32'h0000_0001);
    bus_wr(9'h100, 32'hFFFF_FFFF, 4'hF);
    bus_rd(9'h100, d, e); check("R3 ctrl fields", d, 32'h8000_000F);
    check("R12 conv_en", 32'(conv_en), 1);
    check("R12 settle_mult", 32'(settle_mult), 32'hF);
    bus_wr(9'h100, 32'h0000_0000, 4'b0001);
    bus_rd(9'h100, d, e); check("R3 byte lane gated", d, 32'h8000_0000);
    bus_wr(9'h100, 32'h0000_0005, 4'hF);
    check("R12 conv_en off", 32'(conv_en), 0);
    check("R12 settle_mult 5", 32'(settle_mult), 5);
    bus_wr(9'h01C, 0, 4'hF);
    bus_wr(9'h028, 0, 4'hF);
  endtask

  task automatic t_fifo_basic();
    logic [31:0] d; logic e;
    push(8'hA5); push(8'h3C); push(8'hFF);
    bus_rd(9'h108, d, e); check("R4 occ 3", d, 3);
    bus_rd(9'h104, d, e); check("R4 first", d, 32'hA5); check("R4 no err", 32'(e), 0);
    bus_rd(9'h104, d, e); check("R4 second", d, 32'h3C);
    bus_rd(9'h104, d, e); check("R4 third", d, 32'hFF);
    bus_rd(9'h108, d, e); check("R4 occ 0", d, 0);
  endtask

  task automatic t_empty();
    logic [31:0] d; logic e;
    bus_rd(9'h104, d, e); check("R5 empty err", 32'(e), 1);
    bus_rd(9'h108, d, e); check("R5 occ stays 0", d, 0);
  endtask

  task automatic t_full();
    logic [31:0] d; logic e;
    for (int i = 1; i <= 16; i++) push(SW'(i));
    push(8'hEE);
    bus_rd(9'h108, d, e); check("R6 occ 16", d, 16);
    @(negedge clk);
    smp_valid = 1'b1; smp_data = 8'h77;
    bus_req = 1'b1; bus_we = 1'b0; bus_addr = 9'h104;
    @(posedge clk); @(negedge clk);
    smp_valid = 1'b0; bus_req = 1'b0;
    check("R7 popped head", bus_rdata, 1);
    bus_rd(9'h108, d, e); check("R7 occ 16", d, 16);
    for (int i = 2; i <= 16; i++) begin
      bus_rd(9'h104, d, e); check("R6 order kept", d, 32'(i));
    end
    bus_rd(9'h104, d, e); check("R7 tail sample", d, 32'h77);
    bus_rd(9'h108, d, e); check("R6 drained", d, 0);
  endtask

  task automatic t_status();
    logic [31:0] d; logic e;
    bus_rd(9'h020, d, e); check("R8 set after data", d, 1);
    bus_wr(9'h020, 1, 4'hF);
    bus_rd(9'h020, d, e); check("R9 toggle clears", d, 0);
    bus_wr(9'h020, 1, 4'hF);
    bus_rd(9'h020, d, e); check("R9 toggle sets", d, 1);
    bus_wr(9'h020, 0, 4'hF);
    bus_rd(9'h020, d, e); check("R9 zero no effect", d, 1);
    bus_wr(9'h020, 1, 4'hF);
    push(8'h42);
    repeat (2) @(posedge clk);
    bus_rd(9'h020, d, e); check("R8 set by data", d, 1);
    bus_wr(9'h020, 1, 4'hF);
    bus_rd(9'h020, d, e); check("R8 clear overridden", d, 1);
    bus_rd(9'h104, d, e); check("R8 sample", d, 32'h42);
  endtask

  task automatic t_irq();
    bus_wr(9'h01C, 32'h8000_0000, 4'hF);
    bus_wr(9'h028, 1, 4'hF);
    repeat (2) @(posedge clk);
    @(negedge clk);
    check("R10 irq on", 32'(irq), 1);
    bus_wr(9'h028, 0, 4'hF);
    check("R10 irq one cycle behind", 32'(irq), 1);
    @(posedge clk); @(negedge clk);
    check("R10 irq off by ier", 32'(irq), 0);
    bus_wr(9'h028, 1, 4'hF);
    bus_wr(9'h01C, 0, 4'hF);
    @(posedge clk); @(negedge clk);
    check("R10 irq off by gie", 32'(irq), 0);
    bus_wr(9'h01C, 32'h8000_0000, 4'hF);
    bus_wr(9'h020, 1, 4'hF);
    @(posedge clk); @(negedge clk);
    check("R10 irq off by status", 32'(irq), 0);
  endtask

  task automatic t_ignored();
    logic [31:0] d; logic e;
    push(8'h5A);
    bus_wr(9'h104, 32'hFF, 4'hF);
    bus_wr(9'h108, 32'h1F, 4'hF);
    bus_rd(9'h108, d, e); check("R11 occ unchanged", d, 1);
    bus_rd(9'h104, d, e); check("R11 data unchanged", d, 32'h5A);
    bus_rd(9'h0C0, d, e); check("R11 unmapped zero", d, 0);
    check("R11 unmapped no err", 32'(e), 0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rst = 1'b0;
    t_reset();
    t_ack();
    t_regs();
    t_fifo_basic();
    t_empty();
    t_full();
    t_status();
    t_irq();
    t_ignored();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule